// File: doc/BRIEF.md
# Accelerator Control and Done-Flag Unit

This block is the main 32-bit control and status word of a multi-engine accelerator. Software reaches it through a simple register bus: one write strobe with a data word, and a read word that always shows the current contents. The word holds the configuration that the engines sample: interrupt enable, hash/CRC source select, input and output byte-swap enables, wait-pin enable and polarity, write-FIFO and read-FIFO source selects, a done-flag mode bit and a DMA-done mask bit.

Four engines (DMA, Galois/CRC, hash, cipher) each report completion as a single-cycle pulse. The block turns each pulse into a sticky done flag. It ORs the flags into a summary done bit and drives an interrupt from that bit and a bus-error flag. The flags are either plain read/write or write-1-to-clear, depending on a mode bit that cannot be cleared once set, except by the hardware reset. A mask bit keeps the DMA flag out of the summary and out of the interrupt.

Writing 1 to bit 0 starts a one-cycle soft reset. The soft reset clears the done flags and the bus-error flag and keeps every configuration field. A bus-error pulse sets a read-only error flag that halts the DMA until a soft reset. The hardware reset is asynchronous and active low, and its release is synchronised to the clock.

Top module: `accel_ctl_status`

## Requirements
- R1: While the hardware reset is asserted, the read word is 0xC0000000. Bit 31 (summary done) and bit 30 (ready) read 1, and all other bits read 0.
- R2: A write loads the configuration fields: bit 1 interrupt enable, bit 2 hash/CRC source, bit 4 output swap, bit 5 input swap, bit 6 wait enable, bit 7 wait polarity, bits 9:8 write-FIFO source, bits 11:10 read-FIFO source, bit 15 DMA mask. Bits 3, 12, 13, 23:16 and 28 always read 0 and ignore writes.
- R3: Writing 1 to bit 0 makes bit 0 and the `soft_rst` output read 1 for exactly the next cycle. In the cycle after that, the done flags and the error flag read 0 and every configuration field keeps its value. The soft reset beats a completion or error pulse that arrives in the cycle it is active.
- R4: A pulse on `evt_done[i]` sets done flag i at read bit 24+i on the next cycle. Index 0 is DMA, 1 is Galois/CRC, 2 is hash and 3 is cipher.
- R5: With bit 14 at 0, a write copies bits 27:24 of the write data into the done flags, so both 0 and 1 take effect.
- R6: With bit 14 at 1, writing 1 to a done-flag bit clears that flag and writing 0 leaves it unchanged. The value of bit 14 before the write decides which rule applies.
- R7: Writing 1 to bit 14 sets it. Neither a later write of 0 nor a soft reset clears it; only the hardware reset does.
- R8: Outside reset, bit 31 is the OR of the done flags. When bit 15 is 1, the DMA flag (bit 24) is left out of this OR, although the DMA flag itself still sets and clears.
- R9: `irq` is 1 exactly when bit 1 is 1 and bit 31 or bit 29 is 1.
- R10: A pulse on `evt_bus_err` sets bit 29 and `dma_halt` on the next cycle. Writes do not change bit 29; only a soft reset clears it.
- R11: When a completion pulse and a software clear of the same flag happen in the same cycle, the flag is set afterwards. This holds in both flag modes.
- R12: Bit 30 shows `eng_ready` as registered one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 32 | Register write data |
| evt_done | input | 4 | Completion pulses: DMA, Galois/CRC, hash, cipher |
| evt_bus_err | input | 1 | DMA bus-error pulse |
| eng_ready | input | 1 | Accelerator ready for more data |
| rd_data | output | 32 | Current register contents |
| irq | output | 1 | Interrupt request |
| soft_rst | output | 1 | One-cycle soft reset to the engines |
| dma_halt | output | 1 | Stops the DMA while the error flag is set |

## Verification
A wrong flag or mode state shows up in `rd_data` on the cycle after the event that caused it, and in `irq` in that same cycle, so every check samples one cycle after its stimulus. The harder cases are ordering problems: a pulse colliding with a clear, a soft reset colliding with a pulse, a write that sets the flag mode and touches the flags at once, and the DMA mask removing the DMA flag from the summary while the DMA flag itself still updates. A flag mode that clears by mistake is only visible on a later write, when writing 0 to a set flag clears it. The bench therefore always writes 0 to the mode bit after setting it and reads the flags back.

// File: rtl/accel_ctl_pkg.sv
package accel_ctl_pkg;
  localparam int REG_W   = 32;
  localparam int N_ENG   = 4;
  localparam int SEL_W   = 2;
  // bit positions of the control/status word
  localparam int B_SRST  = 0;
  localparam int B_IEN   = 1;
  localparam int B_HSRC  = 2;
  localparam int B_OSWP  = 4;
  localparam int B_ISWP  = 5;
  localparam int B_WTEN  = 6;
  localparam int B_WTPOL = 7;
  localparam int B_WSRC  = 8;
  localparam int B_RSRC  = 10;
  localparam int B_FMODE = 14;
  localparam int B_DMASK = 15;
  localparam int B_FLAG  = 24;
  localparam int B_ERR   = 29;
  localparam int B_RDY   = 30;
  localparam int B_DONE  = 31;
  localparam int ENG_DMA = 0;

  typedef struct packed {
    logic             ien;
    logic             hsrc;
    logic             oswp;
    logic             iswp;
    logic             wten;
    logic             wtpol;
    logic [SEL_W-1:0] wsrc;
    logic [SEL_W-1:0] rsrc;
    logic             fmode;
    logic             dmask;
  } cfg_t;
endpackage

// File: rtl/acs_rst_sync.sv
module acs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/acs_cfg_reg.sv
module acs_cfg_reg
  import accel_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output cfg_t             cfg_q,
  output cfg_t             cfg_n
);
  always_comb begin
    cfg_n = cfg_q;
    if (wr_en) begin
      cfg_n.ien   = wr_data[B_IEN];
      cfg_n.hsrc  = wr_data[B_HSRC];
      cfg_n.oswp  = wr_data[B_OSWP];
      cfg_n.iswp  = wr_data[B_ISWP];
      cfg_n.wten  = wr_data[B_WTEN];
      cfg_n.wtpol = wr_data[B_WTPOL];
      cfg_n.wsrc  = wr_data[B_WSRC +: SEL_W];
      cfg_n.rsrc  = wr_data[B_RSRC +: SEL_W];
      cfg_n.dmask = wr_data[B_DMASK];
      // mode bit can only be set by software
      cfg_n.fmode = cfg_q.fmode | wr_data[B_FMODE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_n;
  end
endmodule

// File: rtl/acs_done_flags.sv
module acs_done_flags #(
  parameter int N   = 4,
  parameter int MSK = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst,
  input  logic [N-1:0] evt,
  input  logic         wr_en,
  input  logic [N-1:0] wr_flags,
  input  logic         w1c_mode,
  input  logic         mask_n,
  output logic [N-1:0] flags_q,
  output logic         sum_q
);
  logic [N-1:0] flags_n;
  logic [N-1:0] keep;
  logic         sum_n;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      flags_n[i] = flags_q[i];
      if (srst)          flags_n[i] = 1'b0;
      else if (evt[i])   flags_n[i] = 1'b1;
      else if (wr_en) begin
        if (w1c_mode) flags_n[i] = flags_q[i] & ~wr_flags[i];
        else          flags_n[i] = wr_flags[i];
      end
    end
    assign keep[i] = (i == MSK) ? ~mask_n : 1'b1;
  end

  assign sum_n = |(flags_n & keep);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      sum_q   <= 1'b1;
    end else begin
      flags_q <= flags_n;
      sum_q   <= sum_n;
    end
  end
endmodule

// File: rtl/acs_status.sv
module acs_status (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_srst,
  input  logic bus_err,
  input  logic ready_in,
  output logic srst_q,
  output logic err_q,
  output logic rdy_q
);
  logic srst_n, err_n;

  always_comb begin
    srst_n = wr_en & wr_srst;
    if (srst_q)       err_n = 1'b0;
    else if (bus_err) err_n = 1'b1;
    else              err_n = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q <= 1'b0;
      err_q  <= 1'b0;
      rdy_q  <= 1'b1;
    end else begin
      srst_q <= srst_n;
      err_q  <= err_n;
      rdy_q  <= ready_in;
    end
  end
endmodule

// File: rtl/accel_ctl_status.sv
module accel_ctl_status
  import accel_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic [N_ENG-1:0] evt_done,
  input  logic             evt_bus_err,
  input  logic             eng_ready,
  output logic [REG_W-1:0] rd_data,
  output logic             irq,
  output logic             soft_rst,
  output logic             dma_halt
);
  logic             rst_sync_n;
  cfg_t             cfg_q, cfg_n;
  logic [N_ENG-1:0] flags_q;
  logic             sum_q, srst_q, err_q, rdy_q;

  acs_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  acs_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_data(wr_data),
    .cfg_q(cfg_q), .cfg_n(cfg_n)
  );

  acs_done_flags #(.N(N_ENG), .MSK(ENG_DMA)) u_flags (
    .clk(clk), .rst_n(rst_sync_n), .srst(srst_q), .evt(evt_done),
    .wr_en(wr_en), .wr_flags(wr_data[B_FLAG +: N_ENG]),
    .w1c_mode(cfg_q.fmode), .mask_n(cfg_n.dmask),
    .flags_q(flags_q), .sum_q(sum_q)
  );

  acs_status u_stat (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_srst(wr_data[B_SRST]),
    .bus_err(evt_bus_err), .ready_in(eng_ready),
    .srst_q(srst_q), .err_q(err_q), .rdy_q(rdy_q)
  );

  always_comb begin
    rd_data                  = '0;
    rd_data[B_SRST]          = srst_q;
    rd_data[B_IEN]           = cfg_q.ien;
    rd_data[B_HSRC]          = cfg_q.hsrc;
    rd_data[B_OSWP]          = cfg_q.oswp;
    rd_data[B_ISWP]          = cfg_q.iswp;
    rd_data[B_WTEN]          = cfg_q.wten;
    rd_data[B_WTPOL]         = cfg_q.wtpol;
    rd_data[B_WSRC +: SEL_W] = cfg_q.wsrc;
    rd_data[B_RSRC +: SEL_W] = cfg_q.rsrc;
    rd_data[B_FMODE]         = cfg_q.fmode;
    rd_data[B_DMASK]         = cfg_q.dmask;
    rd_data[B_FLAG +: N_ENG] = flags_q;
    rd_data[B_ERR]           = err_q;
    rd_data[B_RDY]           = rdy_q;
    rd_data[B_DONE]          = sum_q;
  end

  assign irq      = cfg_q.ien & (sum_q | err_q);
  assign soft_rst = srst_q;
  assign dma_halt = err_q;
endmodule

// File: rtl/acs_checker.sv
module acs_checker (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [3:0]  evt_done,
  input logic [31:0] rd_data,
  input logic        irq,
  input logic        soft_rst,
  input logic        dma_halt
);
  // R3: soft reset lasts one cycle and only follows a write of bit 0
  a_r3_srst_source: assert property (@(posedge clk) disable iff (!rst_sync_n)
    soft_rst |-> $past(wr_en && wr_data[0]));
  // R3: soft reset clears flags and error
  a_r3_srst_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    soft_rst |=> (rd_data[27:24] == 4'h0 && !rd_data[29]));
  // R7: flag mode never falls outside hardware reset
  a_r7_mode_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_data[14] |=> rd_data[14]);
  // R10: error flag holds until a soft reset
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_data[29] && !soft_rst) |=> rd_data[29]);
  // R10: halt tracks the error flag
  a_r10_halt: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dma_halt == rd_data[29]);
  // R11: a cipher pulse wins over any write
  a_r11_pulse_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (evt_done[3] && !soft_rst) |=> rd_data[27]);
  // R5: free-write mode copies the write data
  a_r5_free_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && !rd_data[14] && !soft_rst && evt_done == 4'h0)
      |=> rd_data[27:24] == $past(wr_data[27:24]));
  // R9: interrupt needs its enable and a cause
  a_r9_irq: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq |-> (rd_data[1] && (rd_data[31] || rd_data[29])));
  // R8: with the mask set, summary done needs a non-DMA flag
  a_r8_mask: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_data[15] && rd_data[31]) |-> (|rd_data[27:25]));
endmodule

bind accel_ctl_status acs_checker u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .wr_en(wr_en), .wr_data(wr_data),
  .evt_done(evt_done), .rd_data(rd_data), .irq(irq), .soft_rst(soft_rst),
  .dma_halt(dma_halt)
);

// File: tb/accel_ctl_status_test.sv
module accel_ctl_status_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [3:0]  evt_done;
  logic        evt_bus_err;
  logic        eng_ready;
  logic [31:0] rd_data;
  logic        irq, soft_rst, dma_halt;

  int checks = 0;
  int errors = 0;
  localparam logic [31:0] CFG = 32'h0000_0FF6;

  accel_ctl_status uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .evt_done(evt_done), .evt_bus_err(evt_bus_err), .eng_ready(eng_ready),
    .rd_data(rd_data), .irq(irq), .soft_rst(soft_rst), .dma_halt(dma_halt)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // one-cycle write, optionally with pulses in the same cycle; sample after
  task automatic cyc(input logic we, input logic [31:0] d, input logic [3:0] ev, input logic be);
    @(negedge clk);
    wr_en = we; wr_data = d; evt_done = ev; evt_bus_err = be;
    @(negedge clk);
    wr_en = 1'b0; evt_done = 4'h0; evt_bus_err = 1'b0;
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset value", rd_data, 32'hC000_0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", rd_data, 32'h4000_0000);
  endtask

  task automatic t_fields();
    cyc(1'b1, 32'h10FF_3008, 4'h0, 1'b0);
    check("R2 reserved bits ignored", rd_data, 32'h4000_0000);
    cyc(1'b1, CFG, 4'h0, 1'b0);
    check("R2 config fields", rd_data, 32'h4000_0FF6);
    check("R9 no cause no irq", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_capture();
    for (int i = 0; i < 4; i++) begin
      cyc(1'b0, 32'h0, 4'(1 << i), 1'b0);
      check("R4 flag position", {28'd0, rd_data[27:24]}, 32'(1 << i));
      check("R8 summary done", {31'd0, rd_data[31]}, 32'd1);
      check("R9 irq on done", {31'd0, irq}, 32'd1);
      cyc(1'b1, CFG, 4'h0, 1'b0);
    end
  endtask

  task automatic t_free_write();
    cyc(1'b1, CFG | 32'h0A00_0000, 4'h0, 1'b0);
    check("R5 write ones", {28'd0, rd_data[27:24]}, 32'hA);
    cyc(1'b1, CFG | 32'h0500_0000, 4'h0, 1'b0);
    check("R5 write zeros clear", {28'd0, rd_data[27:24]}, 32'h5);
    cyc(1'b1, CFG, 4'h0, 1'b0);
  endtask

  task automatic t_mask();
    cyc(1'b1, CFG | 32'h0100_8000, 4'h0, 1'b0);
    check("R8 masked dma flag set", {31'd0, rd_data[24]}, 32'd1);
    check("R8 masked dma no done", {31'd0, rd_data[31]}, 32'd0);
    check("R9 masked dma no irq", {31'd0, irq}, 32'd0);
    cyc(1'b1, CFG | 32'h0100_0000, 4'h0, 1'b0);
    check("R8 unmasked dma done", {31'd0, rd_data[31]}, 32'd1);
    cyc(1'b1, CFG | 32'h0000_8000, 4'h0, 1'b0);
    cyc(1'b0, 32'h0, 4'h1, 1'b0);
    check("R8 masked dma pulse updates flag", {30'd0, rd_data[24], rd_data[31]}, 32'd2);
    cyc(1'b1, (CFG & ~32'h2) | 32'h0400_0000, 4'h0, 1'b0);
    check("R9 disabled irq", {30'd0, rd_data[31], irq}, 32'd2);
    cyc(1'b1, CFG, 4'h0, 1'b0);
  endtask

  task automatic t_err_srst();
    cyc(1'b0, 32'h0, 4'h0, 1'b1);
    check("R10 error set", {29'd0, rd_data[29], dma_halt, irq}, 32'd7);
    cyc(1'b1, CFG | 32'h0300_0000, 4'h0, 1'b0);
    check("R10 write keeps error", {31'd0, rd_data[29]}, 32'd1);
    cyc(1'b1, CFG | 32'h0300_0001, 4'h0, 1'b0);
    check("R3 srst busy", {30'd0, rd_data[0], soft_rst}, 32'd3);
    check("R3 flags before srst", {28'd0, rd_data[27:24]}, 32'h3);
    @(negedge clk);
    check("R3 after srst", rd_data, 32'h4000_0FF6);
    check("R3 srst self-clears", {31'd0, soft_rst}, 32'd0);
    // soft reset beats a pulse in its active cycle
    @(negedge clk);
    wr_en = 1'b1; wr_data = CFG | 32'h1;
    @(negedge clk);
    wr_en = 1'b0; evt_done = 4'h4; evt_bus_err = 1'b1;
    @(negedge clk);
    evt_done = 4'h0; evt_bus_err = 1'b0;
    check("R3 srst beats pulses", rd_data, 32'h4000_0FF6);
  endtask

  task automatic t_collision_free();
    cyc(1'b1, CFG | 32'h0800_0000, 4'h0, 1'b0);
    cyc(1'b1, CFG, 4'h9, 1'b0);
    check("R11 pulse beats clear mode0", {28'd0, rd_data[27:24]}, 32'h9);
    cyc(1'b1, CFG, 4'h0, 1'b0);
  endtask

  task automatic t_w1c();
    cyc(1'b1, CFG | 32'h0F00_4000, 4'h0, 1'b0);
    check("R6 old mode governs write", {27'd0, rd_data[27:24], rd_data[14]}, 32'h1F);
    cyc(1'b1, CFG | 32'h0500_4000, 4'h0, 1'b0);
    check("R6 write one clears", {28'd0, rd_data[27:24]}, 32'hA);
    cyc(1'b1, CFG, 4'h0, 1'b0);
    check("R6 write zero no effect", {28'd0, rd_data[27:24]}, 32'hA);
    check("R7 mode stays after zero", {31'd0, rd_data[14]}, 32'd1);
    cyc(1'b1, CFG | 32'h0800_4000, 4'h8, 1'b0);
    check("R11 pulse beats clear w1c", {28'd0, rd_data[27:24]}, 32'hA);
    cyc(1'b1, CFG | 32'h0F00_0000, 4'h0, 1'b0);
    check("R6 clear all", {28'd0, rd_data[27:24]}, 32'h0);
    cyc(1'b1, CFG | 32'h1, 4'h0, 1'b0);
    @(negedge clk);
    check("R7 mode survives soft reset", {31'd0, rd_data[14]}, 32'd1);
    hw_reset();
    check("R7 hardware reset clears mode", {31'd0, rd_data[14]}, 32'd0);
  endtask

  task automatic t_ready();
    @(negedge clk);
    eng_ready = 1'b0;
    @(negedge clk);
    check("R12 ready low", {31'd0, rd_data[30]}, 32'd0);
    eng_ready = 1'b1;
    @(negedge clk);
    check("R12 ready high", {31'd0, rd_data[30]}, 32'd1);
  endtask

  initial begin
    rst_n = 1'b1; wr_en = 1'b0; wr_data = '0; evt_done = '0;
    evt_bus_err = 1'b0; eng_ready = 1'b1;
    repeat (2) @(negedge clk);
    hw_reset();
    t_fields();
    t_capture();
    t_free_write();
    t_mask();
    t_err_srst();
    t_collision_free();
    t_w1c();
    t_ready();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule